// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the time of day and the calendar date as packed BCD registers and moves them forward by one second each time its one-second tick input is high for a clock cycle. It keeps seconds, minutes, hours in 24-hour form, a day-of-week count, the day of the month, the month, a two-digit year and a single century bit that sits in the hours register. Month lengths are applied automatically, including February in leap years. A leap year is any year whose two BCD digits form a multiple of four, so the rule is exact only up to 2100.

A host loads any field through a synchronous write port, addressed by a 3-bit field selector. A combinational read port returns any field using the same selector. The 1 Hz tick source, oscillator trimming and any bus interface sit outside the block.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the fields read seconds 00, minutes 00, hours 00 with century bit 0, day of week 01, date 01, month 01 and year 00.
- R2: Field selectors: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A tick advances seconds by one in BCD. After 59, seconds go to 00 and minutes advance in the same cycle.
- R3: Minutes wrap from 59 to 00 and advance hours. Hours wrap from 23 to 00 and advance both the date and the day of week in the same cycle.
- R4: Day of week counts 1 to 7 and returns to 1 after 7.
- R5: The date returns to 01 and the month advances after day 30 of months 04, 06, 09 and 11, and after day 31 of months 01, 03, 05, 07, 08, 10 and 12.
- R6: February ends on day 29 when the year's two BCD digits form a multiple of four (00 included), and on day 28 otherwise.
- R7: The month wraps from 12 to 01 and advances the year.
- R8: When the year rolls from 99 to 00, the century bit inverts. The century bit reads as bit 7 of selector 2.
- R9: A write stores wrData masked to the field width. The masks are: seconds and minutes 7Fh, hours 3Fh plus the century in bit 7, day of week 07h, date 3Fh, month 1Fh, year FFh. Bit 6 of selector 2 always reads 0.
- R10: In a cycle with both a write and a tick, the written field takes the written value. Every other field advances as the tick dictates, based on the values held before that cycle.
- R11: With no tick and no write, no field changes.
- R12: Selector 7 reads as 00h. A write to selector 7 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-second advance strobe, one cycle wide |
| wrEn | input | 1 | Write strobe for the selected field |
| wrSel | input | 3 | Field selector for writes |
| wrData | input | 8 | Packed BCD value to write |
| rdSel | input | 3 | Field selector for reads |
| rdData | output | 8 | Selected field, packed BCD |

## Verification
The hardest cases to reach are the long carry chains: the year rollover that flips the century, and the February ends that depend on the leap rule. At one tick per second these take years of ticks to reach from reset. The bench instead writes every field to a value one second before the boundary and then applies a single tick. A tick is also issued in the same cycle as a write, so the override and the carry from the old values are checked together.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = 3;
  localparam int DATA_W     = 8;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] load;
    logic [NUM_FIELDS-1:0] bump;
    logic [NUM_FIELDS-1:0] wrap;
    logic                  loadCent;
    logic                  flipCent;
  } cal_strobe_t;

  function automatic logic [DATA_W-1:0] bcdInc(input logic [DATA_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR:       return 8'h3F;
      F_DOW:        return 8'h07;
      F_DATE:       return 8'h3F;
      F_MON:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fieldFloor(input int idx);
    return (idx == F_DOW || idx == F_DATE || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  // two BCD digits t,u: 10t+u divisible by 4 <=> (2t+u) divisible by 4
  function automatic logic isLeap(input logic [DATA_W-1:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [DATA_W-1:0] monthLen(input logic [DATA_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tickIn,
  input  logic                             wrEn,
  input  logic [SEL_W-1:0]                 wrSel,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldsIn,
  output cal_strobe_t                      strobes
);
  logic [DATA_W-1:0] curLen;

  always_comb begin
    curLen = monthLen(fieldsIn[F_MON], isLeap(fieldsIn[F_YEAR]));

    for (int i = 0; i < NUM_FIELDS; i++)
      strobes.load[i] = wrEn && (wrSel == SEL_W'(i));
    strobes.loadCent = strobes.load[F_HOUR];

    // ordered compare also recovers from out-of-range written values
    strobes.wrap[F_SEC]  = fieldsIn[F_SEC]  >= 8'h59;
    strobes.wrap[F_MIN]  = fieldsIn[F_MIN]  >= 8'h59;
    strobes.wrap[F_HOUR] = fieldsIn[F_HOUR] >= 8'h23;
    strobes.wrap[F_DOW]  = fieldsIn[F_DOW]  >= 8'h07;
    strobes.wrap[F_DATE] = fieldsIn[F_DATE] >= curLen;
    strobes.wrap[F_MON]  = fieldsIn[F_MON]  >= 8'h12;
    strobes.wrap[F_YEAR] = fieldsIn[F_YEAR] >= 8'h99;

    strobes.bump[F_SEC]  = tickIn;
    strobes.bump[F_MIN]  = strobes.bump[F_SEC]  && strobes.wrap[F_SEC];
    strobes.bump[F_HOUR] = strobes.bump[F_MIN]  && strobes.wrap[F_MIN];
    strobes.bump[F_DOW]  = strobes.bump[F_HOUR] && strobes.wrap[F_HOUR];
    strobes.bump[F_DATE] = strobes.bump[F_HOUR] && strobes.wrap[F_HOUR];
    strobes.bump[F_MON]  = strobes.bump[F_DATE] && strobes.wrap[F_DATE];
    strobes.bump[F_YEAR] = strobes.bump[F_MON]  && strobes.wrap[F_MON];
    strobes.flipCent     = strobes.bump[F_YEAR] && strobes.wrap[F_YEAR];
  end

  AST_MONTH_END_DATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bump[F_MON] && !strobes.load[F_DATE]) |=> fieldsIn[F_DATE] == 8'h01); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_W'(F_SEC)) |=> fieldsIn[F_SEC] == ($past(wrData) & 8'h7F)); // R10

  AST_DOW_WITH_DATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bump[F_DATE] && !wrEn) |=> fieldsIn[F_DOW] != $past(fieldsIn[F_DOW])); // R4
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  cal_strobe_t                       strobes,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [SEL_W-1:0]                  rdSel,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldsQ,
  output logic [DATA_W-1:0]                 rdData
);
  logic centQ;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    always_ff @(posedge clk) begin
      if (!rstN)                fieldsQ[g] <= fieldFloor(g);
      else if (strobes.load[g]) fieldsQ[g] <= wrData & fieldMask(g);
      else if (strobes.bump[g]) fieldsQ[g] <= strobes.wrap[g] ? fieldFloor(g)
                                                              : bcdInc(fieldsQ[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 centQ <= 1'b0;
    else if (strobes.loadCent) centQ <= wrData[7];
    else if (strobes.flipCent) centQ <= ~centQ;
  end

  always_comb begin
    if (rdSel == SEL_W'(F_HOUR))           rdData = fieldsQ[F_HOUR] | {centQ, 7'b0};
    else if (int'(rdSel) < NUM_FIELDS)     rdData = fieldsQ[rdSel];
    else                                   rdData = '0;
  end

  AST_CENT_ONLY_AT_ROLL: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCent |=> (centQ == $past(centQ)) ||
                          ($past(fieldsQ[F_YEAR]) >= 8'h99 && fieldsQ[F_YEAR] == 8'h00)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load == '0 && strobes.bump == '0) |=> ($stable(fieldsQ) && $stable(centQ))); // R11
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData
);
  cal_strobe_t                       strobes;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fields;

  cal_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .fieldsIn(fields), .strobes(strobes)
  );

  cal_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdSel(rdSel), .fieldsQ(fields), .rdData(rdData)
  );
endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdSel = '0;
  logic [7:0] rdData;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_calendar i_bcd_calendar (.*);

  task automatic expectField(input string tag, input logic [2:0] sel, input logic [7:0] exp);
    rdSel = sel;
    #0.5;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, rdData, exp);
    end
  endtask

  task automatic writeField(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic tick();
    @(negedge clk); tickIn = 1;
    @(negedge clk); tickIn = 0;
  endtask

  task automatic setAll(input logic [7:0] yr, mon, dt, dw, hr, mn, sc);
    writeField(6, yr); writeField(5, mon); writeField(4, dt); writeField(3, dw);
    writeField(2, hr); writeField(1, mn); writeField(0, sc);
  endtask

  task automatic testReset();
    expectField("R1", 0, 8'h00); expectField("R1", 1, 8'h00);
    expectField("R1", 2, 8'h00); expectField("R1", 3, 8'h01);
    expectField("R1", 4, 8'h01); expectField("R1", 5, 8'h01);
    expectField("R1", 6, 8'h00);
  endtask

  task automatic testSeconds();
    writeField(0, 8'h09); tick(); expectField("R2", 0, 8'h10);
    writeField(1, 8'h05); writeField(0, 8'h59); tick();
    expectField("R2", 0, 8'h00); expectField("R2", 1, 8'h06);
  endtask

  task automatic testHours();
    setAll(8'h25, 8'h05, 8'h09, 8'h02, 8'h09, 8'h59, 8'h59); tick();
    expectField("R3", 2, 8'h10); expectField("R3", 1, 8'h00);
    setAll(8'h25, 8'h05, 8'h10, 8'h03, 8'h23, 8'h59, 8'h59); tick();
    expectField("R3", 2, 8'h00); expectField("R3", 4, 8'h11);
    expectField("R3", 3, 8'h04);
  endtask

  task automatic testDow();
    setAll(8'h25, 8'h05, 8'h12, 8'h07, 8'h23, 8'h59, 8'h59); tick();
    expectField("R4", 3, 8'h01); expectField("R4", 4, 8'h13);
  endtask

  task automatic testMonthLen();
    setAll(8'h25, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59); tick();
    expectField("R5", 4, 8'h01); expectField("R5", 5, 8'h05);
    setAll(8'h25, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59); tick();
    expectField("R5", 4, 8'h31); expectField("R5", 5, 8'h05);
    tick(); tick();
    writeField(2, 8'h23); writeField(1, 8'h59); writeField(0, 8'h59); tick();
    expectField("R5", 4, 8'h01); expectField("R5", 5, 8'h06);
  endtask

  task automatic febCase(input logic [7:0] yr, input logic leap);
    setAll(yr, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tick();
    expectField("R6", 4, leap ? 8'h29 : 8'h01);
    expectField("R6", 5, leap ? 8'h02 : 8'h03);
  endtask

  task automatic testLeap();
    febCase(8'h24, 1); febCase(8'h23, 0); febCase(8'h00, 1);
    febCase(8'h10, 0); febCase(8'h12, 1); febCase(8'h96, 1);
    setAll(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59); tick();
    expectField("R6", 4, 8'h01); expectField("R6", 5, 8'h03);
  endtask

  task automatic testYear();
    setAll(8'h41, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59); tick();
    expectField("R7", 5, 8'h01); expectField("R7", 6, 8'h42);
    expectField("R7", 4, 8'h01);
  endtask

  task automatic testCentury();
    setAll(8'h99, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59); tick();
    expectField("R8", 6, 8'h00); expectField("R8", 2, 8'h80);
    writeField(6, 8'h99); writeField(5, 8'h12); writeField(4, 8'h31);
    writeField(1, 8'h59); writeField(0, 8'h59);
    writeField(2, 8'hA3); tick();
    expectField("R8", 2, 8'h00);
  endtask

  task automatic testMasks();
    writeField(3, 8'h0F); expectField("R9", 3, 8'h07);
    writeField(5, 8'hFF); expectField("R9", 5, 8'h1F);
    writeField(2, 8'hFF); expectField("R9", 2, 8'hBF);
    writeField(0, 8'hC5); expectField("R9", 0, 8'h45);
  endtask

  task automatic testPriority();
    setAll(8'h25, 8'h05, 8'h10, 8'h01, 8'h08, 8'h10, 8'h10);
    @(negedge clk); wrEn = 1; wrSel = 0; wrData = 8'h30; tickIn = 1;
    @(negedge clk); wrEn = 0; tickIn = 0;
    expectField("R10", 0, 8'h30); expectField("R10", 1, 8'h10);
    writeField(0, 8'h59);
    @(negedge clk); wrEn = 1; wrSel = 1; wrData = 8'h20; tickIn = 1;
    @(negedge clk); wrEn = 0; tickIn = 0;
    expectField("R10", 0, 8'h00); expectField("R10", 1, 8'h20);
  endtask

  task automatic testIdle();
    setAll(8'h31, 8'h07, 8'h15, 8'h05, 8'h12, 8'h34, 8'h56);
    repeat (10) @(negedge clk);
    expectField("R11", 0, 8'h56); expectField("R11", 1, 8'h34);
    expectField("R11", 4, 8'h15);
  endtask

  task automatic testUnused();
    writeField(7, 8'h77);
    expectField("R12", 7, 8'h00); expectField("R12", 0, 8'h56);
    expectField("R12", 6, 8'h31); expectField("R12", 2, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset(); testSeconds(); testHours(); testDow(); testMonthLen();
    testLeap(); testYear(); testCentury(); testMasks(); testPriority();
    testIdle(); testUnused();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule